// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block takes a quad-bank single-data-rate SDRAM from power-up to a usable state. After synchronous reset it drives the memory's command, address, bank, clock-enable and data-mask pins through a fixed sequence:

- a settle window of NOP-only cycles;
- a precharge of every bank;
- a programmable number of auto-refresh commands;
- one load of the mode register with a value set by a parameter.

Between commands it inserts NOP gaps of parameterized length. It then raises a done flag, which tells the memory controller beside it that operational commands may start.

The settle window is given in microseconds and converted to clock cycles from a clock-frequency parameter. With the default values (100 MHz and 200 µs) the window is 20000 cycles. Every pin comes from a register, so the memory sees stable values at each rising clock edge. Clock-enable and data-mask are held high for the whole sequence.

Top module: `sdboot_init_seq`

## Requirements
- R1: While reset is high, and on the clock edge that ends it, the outputs are CKE=1, all DQM bits 1, init_done=0, command NOP ({cs_n,ras_n,cas_n,we_n}=4'b0111), address 0 and bank 0.
- R2: sd_cke and every bit of sd_dqm stay 1 on every cycle after reset.
- R3: All pins are registered. The command is NOP on edges 1 to SETTLE_CYC after reset is released, where SETTLE_CYC = CLK_MHZ*SETTLE_US. No other command appears before edge SETTLE_CYC+1.
- R4: On edge SETTLE_CYC+1 a precharge-all is issued: command 4'b0010, address bit 10 set, all other address bits 0, bank 0.
- R5: Exactly T_RP NOP cycles follow the precharge, and the first auto-refresh comes on the next edge.
- R6: N_REF auto-refresh commands (command 4'b0001, address 0, bank 0) are issued. Each one is followed by exactly T_RFC NOP cycles.
- R7: On the edge after the last refresh gap, exactly one load-mode command is issued: command 4'b0000, address equal to MODE_WORD, bank 0. It comes only after all N_REF refreshes.
- R8: After the load-mode command there are T_MRD NOP cycles. init_done rises on the edge after them and stays 1 until reset, with the command held at NOP.
- R9: A synchronous reset at any point clears init_done, returns the pins to the R1 state and restarts the whole sequence from the settle window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all outputs change on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sd_cke | output | 1 | Memory clock enable, held high |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ROW_W | Address bus (bit 10 = all-bank precharge, mode word on load) |
| sd_ba | output | BANK_W | Bank select, 0 throughout |
| sd_dqm | output | DQM_W | Data mask, held high |
| init_done | output | 1 | High once the memory accepts operational commands |

## Verification
The sequence is walked edge by edge against a table of expected command events. Any cycle not in the table must be a NOP, so a command that comes early or late, or a gap length that is off by one, shows up as a mismatch on that exact edge.

The walk is repeated under three reset patterns:
- a reset after init_done, which shows the done flag is sticky and is cleared only by reset;
- a reset in the middle of the refresh series, which shows the sequencer restarts from the settle window rather than resuming;
- a plain restart from cold.

Separate checks of the address word on the precharge and load-mode edges tell the bit-10 precharge form apart from the mode value.

// File: rtl/sdboot_pkg.sv
package sdboot_pkg;
  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111
  } sd_cmd_e;

  // phase names the command that is issued when the current gap ends
  typedef enum logic [2:0] {
    PH_PRE,
    PH_REF,
    PH_MRS,
    PH_FIN,
    PH_IDLE
  } phase_e;
endpackage

// File: rtl/sdboot_gap_timer.sv
module sdboot_gap_timer #(
  parameter int CNT_W   = 16,
  parameter int RST_VAL = 100
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= CNT_W'(RST_VAL);
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/sdboot_phase_fsm.sv
module sdboot_phase_fsm
  import sdboot_pkg::*;
#(
  parameter int N_REF = 8,
  parameter int T_RP  = 2,
  parameter int T_RFC = 7,
  parameter int T_MRD = 2,
  parameter int CNT_W = 16,
  localparam int REF_W = $clog2(N_REF + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             zero,
  output logic             fire,
  output logic [CNT_W-1:0] gap,
  output sd_cmd_e          cmd,
  output logic             fin
);
  phase_e           phase;
  logic [REF_W-1:0] refs;

  assign fire = zero && (phase != PH_IDLE);

  always_comb begin
    cmd = CMD_NOP;
    gap = '0;
    fin = 1'b0;
    case (phase)
      PH_PRE:  begin cmd = CMD_PRE; gap = CNT_W'(T_RP);  end
      PH_REF:  begin cmd = CMD_REF; gap = CNT_W'(T_RFC); end
      PH_MRS:  begin cmd = CMD_MRS; gap = CNT_W'(T_MRD); end
      PH_FIN:  fin = 1'b1;
      default: ;
    endcase
    if (!fire) begin
      cmd = CMD_NOP;
      fin = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_PRE;
      refs  <= '0;
    end else if (fire) begin
      case (phase)
        PH_PRE: phase <= PH_REF;
        PH_REF: begin
          refs <= refs + 1'b1;
          if (refs == REF_W'(N_REF - 1)) phase <= PH_MRS;
        end
        PH_MRS: phase <= PH_FIN;
        PH_FIN: phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sdboot_pin_drv.sv
module sdboot_pin_drv
  import sdboot_pkg::*;
#(
  parameter int ROW_W  = 13,
  parameter int BANK_W = 2,
  parameter int DQM_W  = 2,
  parameter logic [ROW_W-1:0] MODE_WORD = 'h033,
  localparam int ALLBANK_BIT = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  sd_cmd_e           cmd,
  input  logic              fin,
  output logic              sd_cke,
  output logic [3:0]        cmd_pins,
  output logic [ROW_W-1:0]  sd_addr,
  output logic [BANK_W-1:0] sd_ba,
  output logic [DQM_W-1:0]  sd_dqm,
  output logic              init_done
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_pins  <= CMD_NOP;
      sd_addr   <= '0;
      sd_ba     <= '0;
      sd_cke    <= 1'b1;
      sd_dqm    <= '1;
      init_done <= 1'b0;
    end else begin
      cmd_pins <= cmd;
      sd_cke   <= 1'b1;
      sd_dqm   <= '1;
      sd_ba    <= '0;
      case (cmd)
        CMD_PRE: sd_addr <= ROW_W'(1) << ALLBANK_BIT;
        CMD_MRS: sd_addr <= MODE_WORD;
        default: sd_addr <= '0;
      endcase
      if (fin) init_done <= 1'b1;
    end
  end
endmodule

// File: rtl/sdboot_init_seq.sv
module sdboot_init_seq
  import sdboot_pkg::*;
#(
  parameter int CLK_MHZ   = 100,
  parameter int SETTLE_US = 200,
  parameter int N_REF     = 8,
  parameter int T_RP      = 2,
  parameter int T_RFC     = 7,
  parameter int T_MRD     = 2,
  parameter int ROW_W     = 13,
  parameter int BANK_W    = 2,
  parameter int DQM_W     = 2,
  parameter logic [ROW_W-1:0] MODE_WORD = 'h033,
  localparam int SETTLE_CYC = CLK_MHZ * SETTLE_US,
  localparam int CNT_W      = $clog2(SETTLE_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst,
  output logic              sd_cke,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [ROW_W-1:0]  sd_addr,
  output logic [BANK_W-1:0] sd_ba,
  output logic [DQM_W-1:0]  sd_dqm,
  output logic              init_done
);
  logic             zero, fire, fin;
  logic [CNT_W-1:0] gap;
  sd_cmd_e          cmd;
  logic [3:0]       cmd_pins;

  sdboot_gap_timer #(.CNT_W(CNT_W), .RST_VAL(SETTLE_CYC)) u_timer (
    .clk(clk), .rst(rst), .load(fire), .load_val(gap), .zero(zero)
  );

  sdboot_phase_fsm #(
    .N_REF(N_REF), .T_RP(T_RP), .T_RFC(T_RFC), .T_MRD(T_MRD), .CNT_W(CNT_W)
  ) u_fsm (
    .clk(clk), .rst(rst), .zero(zero), .fire(fire), .gap(gap), .cmd(cmd), .fin(fin)
  );

  sdboot_pin_drv #(
    .ROW_W(ROW_W), .BANK_W(BANK_W), .DQM_W(DQM_W), .MODE_WORD(MODE_WORD)
  ) u_pins (
    .clk(clk), .rst(rst), .cmd(cmd), .fin(fin), .sd_cke(sd_cke),
    .cmd_pins(cmd_pins), .sd_addr(sd_addr), .sd_ba(sd_ba), .sd_dqm(sd_dqm),
    .init_done(init_done)
  );

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_pins;
endmodule

// File: rtl/sdboot_checker.sv
module sdboot_checker #(
  parameter int SETTLE_CYC = 20000,
  parameter int N_REF      = 8,
  parameter int ROW_W      = 13,
  parameter int BANK_W     = 2,
  parameter int DQM_W      = 2,
  parameter logic [ROW_W-1:0] MODE_WORD = 'h033
) (
  input logic              clk,
  input logic              rst,
  input logic              sd_cke,
  input logic              sd_cs_n,
  input logic              sd_ras_n,
  input logic              sd_cas_n,
  input logic              sd_we_n,
  input logic [ROW_W-1:0]  sd_addr,
  input logic [BANK_W-1:0] sd_ba,
  input logic [DQM_W-1:0]  sd_dqm,
  input logic              init_done
);
  logic [3:0]  pcmd;
  logic [31:0] since;
  logic [15:0] refs_seen;
  logic        mrs_seen;

  assign pcmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

  always_ff @(posedge clk) begin
    if (rst) begin
      since     <= '0;
      refs_seen <= '0;
      mrs_seen  <= 1'b0;
    end else begin
      if (since != 32'hFFFF_FFFF) since <= since + 1'b1;
      if (pcmd == 4'b0001 && refs_seen != 16'hFFFF) refs_seen <= refs_seen + 1'b1;
      if (pcmd == 4'b0000) mrs_seen <= 1'b1;
    end
  end

  assert_pins_high_R2: assert property (@(posedge clk) disable iff (rst)
    sd_cke && (&sd_dqm));

  assert_settle_nop_R3: assert property (@(posedge clk) disable iff (rst)
    (pcmd != 4'b0111) |-> (since > 32'(SETTLE_CYC)));

  assert_pre_allbank_R4: assert property (@(posedge clk) disable iff (rst)
    (pcmd == 4'b0010) |-> (sd_addr[10] && sd_ba == '0));

  assert_cmd_gap_R5: assert property (@(posedge clk) disable iff (rst)
    (pcmd != 4'b0111) |=> (pcmd == 4'b0111));

  assert_mode_after_ref_R7: assert property (@(posedge clk) disable iff (rst)
    (pcmd == 4'b0000) |-> (refs_seen >= 16'(N_REF) && sd_addr == MODE_WORD && !mrs_seen));

  assert_done_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done);

  assert_done_needs_mode_R8: assert property (@(posedge clk) disable iff (rst)
    init_done |-> (mrs_seen && pcmd == 4'b0111));
endmodule

bind sdboot_init_seq sdboot_checker #(
  .SETTLE_CYC(SETTLE_CYC), .N_REF(N_REF), .ROW_W(ROW_W), .BANK_W(BANK_W),
  .DQM_W(DQM_W), .MODE_WORD(MODE_WORD)
) u_chk (.*);

// File: tb/sdboot_init_seq_bench.sv
module sdboot_init_seq_bench;
  localparam int CLK_MHZ = 100, SETTLE_US = 200, N_REF = 8;
  localparam int T_RP = 2, T_RFC = 7, T_MRD = 2;
  localparam int ROW_W = 13, BANK_W = 2, DQM_W = 2;
  localparam logic [ROW_W-1:0] MODE_WORD = 13'h033;

  localparam int S     = CLK_MHZ * SETTLE_US;
  localparam int P     = S + 1;
  localparam int R0    = P + T_RP + 1;
  localparam int STEP  = T_RFC + 1;
  localparam int M     = R0 + N_REF * STEP;
  localparam int DONE_EDGE = M + T_MRD + 1;
  localparam int NEV   = 10;

  localparam int EV_EDGE [NEV] = '{P, R0, R0+STEP, R0+2*STEP, R0+3*STEP,
    R0+4*STEP, R0+5*STEP, R0+6*STEP, R0+7*STEP, M};
  localparam logic [3:0] EV_CMD [NEV] = '{4'b0010, 4'b0001, 4'b0001, 4'b0001,
    4'b0001, 4'b0001, 4'b0001, 4'b0001, 4'b0001, 4'b0000};
  localparam logic [ROW_W-1:0] EV_ADDR [NEV] = '{13'h400, 13'h0, 13'h0, 13'h0,
    13'h0, 13'h0, 13'h0, 13'h0, 13'h0, MODE_WORD};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, init_done;
  logic [ROW_W-1:0]  sd_addr;
  logic [BANK_W-1:0] sd_ba;
  logic [DQM_W-1:0]  sd_dqm;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  sdboot_init_seq u_sdboot_init_seq (
    .clk(clk), .rst(rst), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
    .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_addr(sd_addr), .sd_ba(sd_ba),
    .sd_dqm(sd_dqm), .init_done(init_done)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] pin_word();
    return 32'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_addr, sd_ba});
  endfunction

  // walk edges 1..last after reset release, comparing against the event table
  task automatic run_walk(input int last);
    for (int e = 1; e <= last; e++) begin
      logic [3:0]       ecmd;
      logic [ROW_W-1:0] eaddr;
      string            tag;
      @(posedge clk); #1;
      ecmd = 4'b0111; eaddr = '0;
      if (e <= S)       tag = "R3";
      else if (e < R0)  tag = "R5";
      else if (e < M)   tag = "R6";
      else              tag = "R8";
      for (int k = 0; k < NEV; k++) begin
        if (EV_EDGE[k] == e) begin
          ecmd  = EV_CMD[k];
          eaddr = EV_ADDR[k];
          tag   = (k == 0) ? "R4" : (k == NEV-1) ? "R7" : "R6";
        end
      end
      check(tag, pin_word(), 32'({ecmd, eaddr, {BANK_W{1'b0}}}));
      check("R2", 32'({sd_cke, sd_dqm}), 32'({1'b1, {DQM_W{1'b1}}}));
      check("R8", 32'(init_done), 32'(e >= DONE_EDGE));
    end
  endtask

  task automatic check_reset_state(input string req);
    check(req, pin_word(), 32'({4'b0111, {ROW_W{1'b0}}, {BANK_W{1'b0}}}));
    check(req, 32'({sd_cke, sd_dqm, init_done}), 32'({1'b1, {DQM_W{1'b1}}, 1'b0}));
  endtask

  task automatic pulse_reset(input int cycles, input string req);
    @(negedge clk); rst = 1'b1;
    for (int i = 0; i < cycles; i++) begin
      @(posedge clk); #1;
      check_reset_state(req);
    end
    @(negedge clk); rst = 1'b0;
  endtask

  initial begin
    // R1: reset state held for several cycles
    pulse_reset(5, "R1");
    // R3..R8: full sequence from cold, then done held
    run_walk(DONE_EDGE + 50);
    // R9: reset after done clears the flag and restarts
    pulse_reset(3, "R9");
    // R9: reset in the middle of the refresh series
    run_walk(R0 + 3 * STEP + 2);
    pulse_reset(2, "R9");
    // R9: the complete sequence runs again from the settle window
    run_walk(DONE_EDGE + 5);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule